// File: doc/BRIEF.md
# NRZ Bit Sampler with Edge Resynchronization

This block turns an oversampled single-wire NRZ line into a stream of bits. A clock-enable input marks each line sample, and a parameter sets how many samples make up one bit. The bus rate is therefore chosen by how often the enable fires. At 8 samples per bit, a 250 MHz clock with the enable every 3, 6 or 12 cycles is close to 10, 5 or 2.5 Mbit/s.

While idle the block watches for the line to go low (dominant). It counts how many samples the line stays low. When the line returns high, that sample becomes the timing anchor. The block then pulses a start indication and publishes the measured low length, so that the frame parser can check the start sequence.

Bits are taken half a bit after the anchor and then once per bit period. Every falling edge seen while receiving becomes a new anchor, so the sampling phase follows the transmitter even when the two rates differ slightly. The block can decide each bit either from the single centre sample or from a majority of five samples around the centre. The parser can force the block back to idle at any time.

Top module: `nrz_bit_sampler`

## Requirements
- R1: After reset `bit_vld` and `sot` are 0 and `low_len` is 0.
- R2: In idle, a line that stays high produces no `bit_vld` and no `sot` pulse.
- R3: In idle, a low sample starts the start sequence and counts as low sample 1. Each further low sample adds one. The first high sample after that raises `sot` for exactly one clock and loads the count into `low_len`. `low_len` changes at no other time.
- R4: `low_len` saturates at 2^LOW_W-1 when the low period is longer than that.
- R5: The first decision point is HALF = SPB/2 sample enables after the anchoring high sample. Later decision points follow every SPB enables. Each decided bit appears on `bit_val` together with a one-clock `bit_vld` pulse. Stream bit 0 is the high bit that ends the start sequence.
- R6: Every sample enable on which the line is seen falling (high on the previous enable, low now) while receiving becomes a new anchor. The next decision point is then HALF enables later. Bits stretched or shrunk by one sample per bit are still decoded correctly when a falling edge occurs at least every two bits.
- R7: With `vote_en` = 1, each bit is the majority of the 5 consecutive samples at offsets -2..+2 around the decision point. It is reported at the enable of offset +2, so a single flipped sample has no effect.
- R8: With `vote_en` = 0, each bit is the single line sample at the decision point.
- R9: `abort` returns the block to idle by the next clock and cancels any pending decision. No further `bit_vld` is produced until a new low start sequence has ended.
- R10: Only clocks with `smp_en` = 1 advance timing, counting and the vote history. Idle clocks between enables have no effect on the decoded bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Line sample enable, one clock per sample |
| rx | input | 1 | NRZ line level, 0 = dominant |
| abort | input | 1 | Return to idle, from the frame parser |
| vote_en | input | 1 | 1 = five-sample majority, 0 = centre sample |
| bit_val | output | 1 | Decided bit value |
| bit_vld | output | 1 | One-clock strobe for `bit_val` |
| sot | output | 1 | One-clock pulse at the end of the start sequence |
| low_len | output | LOW_W | Measured low length of the last start sequence, in samples |

## Verification
The embedded assertions check the properties that hold on every cycle. These are: `sot` is a single-clock pulse, `low_len` changes only together with it, abort empties the receive state on the next clock, the phase counter stays inside one bit period, and bit strobes appear only while receiving and never on consecutive clocks. Whether the decision points fall at the right offsets, whether re-anchoring really tracks a fast or slow transmitter, and whether the vote rejects a glitch that the centre sample accepts are shown only by the bench's frames. These frames vary the bit length, the enable spacing, the decision mode, the glitches, the start-sequence length and the abort timing.

// File: rtl/nrz_sampler_pkg.sv
package nrz_sampler_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_RECV = 2'd2
  } line_state_t;

  // majority of five line samples
  function automatic logic maj5(input logic [4:0] v);
    return ($countones(v) >= 3);
  endfunction

endpackage

// File: rtl/nrz_start_detect.sv
module nrz_start_detect
  import nrz_sampler_pkg::*;
#(
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic             rx,
  input  logic             abort,
  output logic             receiving,
  output logic             anchor,
  output logic             fall,
  output logic             sot,
  output logic [LOW_W-1:0] low_len
);

  localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}};

  line_state_t      state;
  logic             prev_rx;
  logic [LOW_W-1:0] low_cnt;

  assign receiving = (state == ST_RECV);
  assign anchor    = smp_en && !abort && (state == ST_LOW) && rx;
  assign fall      = smp_en && !abort && (state == ST_RECV) && prev_rx && !rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      prev_rx <= 1'b1;
      low_cnt <= '0;
      sot     <= 1'b0;
      low_len <= '0;
    end else begin
      sot <= 1'b0;
      if (smp_en) prev_rx <= rx;
      if (abort) begin
        state <= ST_IDLE;
      end else if (smp_en) begin
        unique case (state)
          ST_IDLE: begin
            if (!rx) begin
              state   <= ST_LOW;
              low_cnt <= LOW_W'(1);
            end
          end
          ST_LOW: begin
            if (rx) begin
              state   <= ST_RECV;
              sot     <= 1'b1;
              low_len <= low_cnt;
            end else if (low_cnt != LOW_MAX) begin
              low_cnt <= low_cnt + LOW_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_sot_single: assert property (@(posedge clk) disable iff (rst)
    sot |=> !sot);

  a_r3_len_with_sot: assert property (@(posedge clk) disable iff (rst)
    !$stable(low_len) |-> sot);

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!receiving && !sot));

endmodule

// File: rtl/nrz_phase_timer.sv
module nrz_phase_timer #(
  parameter int SPB = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic live,
  input  logic anchor,
  input  logic fall,
  output logic dec_pt
);

  localparam int CNT_W = (SPB > 2) ? $clog2(SPB) : 1;
  localparam int HALF  = SPB / 2;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(SPB - 1);
  localparam logic [CNT_W-1:0] MID    = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] AFTER0 = CNT_W'(1);

  // offset of the current sample from the latest anchor, modulo SPB
  logic [CNT_W-1:0] phase;

  assign dec_pt = smp_en && live && !fall && (phase == MID);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (anchor || fall) begin
      phase <= AFTER0;
    end else if (smp_en && live) begin
      phase <= (phase == LAST) ? '0 : phase + CNT_W'(1);
    end
  end

  a_r5_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

  a_r6_point_spacing: assert property (@(posedge clk) disable iff (rst)
    dec_pt |=> !dec_pt);

endmodule

// File: rtl/nrz_bit_decide.sv
module nrz_bit_decide
  import nrz_sampler_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic rx,
  input  logic live,
  input  logic dec_pt,
  input  logic vote_en,
  output logic bit_val,
  output logic bit_vld
);

  logic [3:0] hist;     // hist[0] = previous sample
  logic [1:0] pend;     // delay line for vote decisions

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      pend    <= '0;
      bit_val <= 1'b0;
      bit_vld <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (smp_en) hist <= {hist[2:0], rx};
      if (!live) begin
        pend <= '0;
      end else if (smp_en) begin
        pend <= {pend[0], dec_pt && vote_en};
        if (dec_pt && !vote_en) begin
          bit_val <= rx;
          bit_vld <= 1'b1;
        end else if (pend[1]) begin
          bit_val <= maj5({hist, rx});
          bit_vld <= 1'b1;
        end
      end
    end
  end

  a_r9_strobe_when_live: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> $past(live && smp_en));

  a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);

endmodule

// File: rtl/nrz_bit_sampler.sv
module nrz_bit_sampler #(
  parameter int SPB   = 8,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic             rx,
  input  logic             abort,
  input  logic             vote_en,
  output logic             bit_val,
  output logic             bit_vld,
  output logic             sot,
  output logic [LOW_W-1:0] low_len
);

  logic receiving, anchor, fall, dec_pt, live;

  assign live = receiving && !abort;

  nrz_start_detect #(.LOW_W(LOW_W)) u_start (
    .clk       (clk),
    .rst       (rst),
    .smp_en    (smp_en),
    .rx        (rx),
    .abort     (abort),
    .receiving (receiving),
    .anchor    (anchor),
    .fall      (fall),
    .sot       (sot),
    .low_len   (low_len)
  );

  nrz_phase_timer #(.SPB(SPB)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .smp_en (smp_en),
    .live   (live),
    .anchor (anchor),
    .fall   (fall),
    .dec_pt (dec_pt)
  );

  nrz_bit_decide u_decide (
    .clk     (clk),
    .rst     (rst),
    .smp_en  (smp_en),
    .rx      (rx),
    .live    (live),
    .dec_pt  (dec_pt),
    .vote_en (vote_en),
    .bit_val (bit_val),
    .bit_vld (bit_vld)
  );

  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    (bit_vld || sot) |-> $past(smp_en));

endmodule

// File: tb/nrz_bit_sampler_test.sv
`timescale 1ns/1ps
module nrz_bit_sampler_test;

  localparam int SPB = 8;
  localparam int LOW_W = 8;
  localparam int NV = 7;
  localparam int NB = 16;

  // stimulus table: pattern (bit i = stream bit i), low samples, samples per
  // sent bit, enable spacing, glitched bit (-1 none), vote mode, expected word
  localparam int PAT  [NV] = '{32'hA5A5, 32'hA5A5, 32'h5555, 32'h5555, 32'h3331, 32'h3331, 32'hA5A5};
  localparam int LOWV [NV] = '{11, 5, 9, 7, 6, 6, 300};
  localparam int SPBA [NV] = '{8, 8, 9, 7, 8, 8, 8};
  localparam int DIVV [NV] = '{1, 2, 4, 1, 1, 3, 1};
  localparam int GLT  [NV] = '{-1, -1, -1, -1, 2, 2, -1};
  localparam int VOTE [NV] = '{0, 1, 0, 1, 0, 1, 0};
  localparam int EXPW [NV] = '{32'hA5A5, 32'hA5A5, 32'h5555, 32'h5555, 32'h3335, 32'h3331, 32'hA5A5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic rx = 1'b1;
  logic abort = 1'b0;
  logic vote_en = 1'b0;
  logic bit_val, bit_vld, sot;
  logic [LOW_W-1:0] low_len;

  int n_chk = 0;
  int n_fail = 0;
  int ncap = 0;
  int nsot = 0;
  logic [31:0] capw = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nrz_bit_sampler #(.SPB(SPB), .LOW_W(LOW_W)) uut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .rx(rx), .abort(abort),
    .vote_en(vote_en), .bit_val(bit_val), .bit_vld(bit_vld),
    .sot(sot), .low_len(low_len)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (bit_vld) begin
        if (ncap < 32) capw[ncap] = bit_val;
        ncap = ncap + 1;
      end
      if (sot) nsot = nsot + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic tick(input logic v, input int div);
    @(negedge clk);
    rx = v;
    smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    for (int k = 1; k < div; k++) @(negedge clk);
  endtask

  task automatic clear_cap();
    ncap = 0;
    nsot = 0;
    capw = '0;
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  task automatic send_frame(input int pat, input int low, input int spba,
                            input int div, input int glt);
    for (int i = 0; i < 4; i++) tick(1'b1, div);
    for (int i = 0; i < low; i++) tick(1'b0, div);
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < spba; s++) begin
        logic v;
        v = pat[b];
        if (b == glt && s == SPB / 2) v = ~v;
        tick(v, div);
      end
    end
    for (int i = 0; i < 3 * spba; i++) tick(1'b1, div);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 bit_vld", int'(bit_vld), 0);
    chk("R1 sot", int'(sot), 0);
    chk("R1 low_len", int'(low_len), 0);

    // R2: high line in idle
    for (int i = 0; i < 20; i++) tick(1'b1, 1);
    chk("R2 no strobes", ncap, 0);
    chk("R2 no sot", nsot, 0);

    // table-driven frames (R3..R8, R10)
    for (int v = 0; v < NV; v++) begin
      int exp_low;
      clear_cap();
      vote_en = VOTE[v][0];
      send_frame(PAT[v], LOWV[v], SPBA[v], DIVV[v], GLT[v]);
      exp_low = (LOWV[v] > 255) ? 255 : LOWV[v];
      chk($sformatf("R3 sot count v%0d", v), nsot, 1);
      chk($sformatf("R3/R4 low_len v%0d", v), int'(low_len), exp_low);
      chk($sformatf("R5 bit count v%0d", v), int'(ncap >= NB), 1);
      // R6 re-anchor (v2,v3), R7 vote (v1,v3,v5), R8 single sample (v4), R10 spacing
      chk($sformatf("R5/R6/R7/R8/R10 bits v%0d", v), int'(capw[NB-1:0]), EXPW[v] & 32'hFFFF);
      pulse_abort();
    end

    // R9: abort mid frame, then a high line must stay silent
    begin
      int n0;
      clear_cap();
      vote_en = 1'b1;
      for (int i = 0; i < 4; i++) tick(1'b1, 1);
      for (int i = 0; i < 6; i++) tick(1'b0, 1);
      for (int s = 0; s < SPB + SPB / 2 + 1; s++) tick(1'b1, 1);
      pulse_abort();
      n0 = ncap;
      chk("R9 bits before abort", n0, 1);
      for (int i = 0; i < 5 * SPB; i++) tick(1'b1, 1);
      chk("R9 silent after abort", ncap, n0);
      chk("R9 no new sot", nsot, 1);
      clear_cap();
      vote_en = 1'b0;
      send_frame(32'h0000C3A7, 4, SPB, 1, -1);
      chk("R9 restart sot", nsot, 1);
      chk("R9 restart low_len", int'(low_len), 4);
      chk("R9 restart bits", int'(capw[NB-1:0]), 32'hC3A7);
      pulse_abort();
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule